// File: doc/BRIEF.md
# Active-Low Byte Handshake Transfer Engine

This block moves bytes between a host and a peripheral without a serial clock. The host drives two active-low lines, a transfer-in-progress line and an acknowledge line, by writing a port byte. The peripheral answers on an active-low request line. Each host write that changes the pair of host lines moves exactly one byte. When the shift direction is outbound, the byte the host left in the shift register is appended to an outbound packet buffer. When the direction is inbound, the next pending byte of an inbound packet is placed in the shift register for the host to read. Every byte step, and every packet boundary, produces a one-cycle shift event pulse.

When the host releases the transfer-in-progress line, the outbound packet is closed. A one-cycle completion pulse reports its length, and the buffer index returns to zero. While the bus is idle, the request line either follows the acknowledge line or signals that unread inbound bytes are waiting. The peripheral side fills an inbound store and loads a packet length. Loading a packet restarts the read position and re-evaluates the lines. What the bytes mean is left to the logic that uses this block.

Top module: `hs_xfer_engine`

## Requirements
- R1: After reset, treq_n is 1, shift_data is 0x00, and sr_evt and pkt_done are 0. The host lines are taken as released (1).
- R2: The host writes the port with pb_wr. Bit 5 is tip_n and bit 4 is tack_n; the other bits are ignored. While tip_n is 0 and the direction bit is 1, each port write that changes {tack_n, tip_n} stores the shift register value into the next outbound slot. The cycle after the write, sr_evt is 1 for one cycle. The direction is bit 4 of ctl_wdata, written with ctl_wr.
- R3: Once OUT_DEPTH bytes are stored, further outbound line changes store nothing and raise no sr_evt.
- R4: While tip_n is 0 and the direction bit is 0, each change of {tack_n, tip_n} with inbound bytes pending loads the next inbound byte into shift_data and pulses sr_evt.
- R5: When the last pending inbound byte is loaded, treq_n goes to 1 in the same cycle that the byte appears.
- R6: While tip_n is 1 and was already 1 at the previous update, a change of tack_n makes treq_n equal to tack_n and pulses sr_evt.
- R7: When tip_n returns to 1 after being 0, sr_evt pulses. If at least one byte was stored, pkt_done pulses for one cycle with pkt_len equal to the stored count. The next outbound byte then goes to slot 0.
- R8: While idle, treq_n goes to 0 whenever unread inbound bytes remain at an update.
- R9: in_load sets the packet size to in_len, restarts the read position at byte 0, re-evaluates the lines and pulses sr_evt.
- R10: A port or control write that leaves {tack_n, tip_n} unchanged moves no byte and raises no sr_evt, except where R7 or R9 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pb_wr | input | 1 | Host port write strobe |
| pb_wdata | input | 8 | Host port value; bit 5 is tip_n, bit 4 is tack_n |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control value; bit 4 is the direction (1 means outbound) |
| sr_wr | input | 1 | Host write of the shift register |
| sr_wdata | input | 8 | Shift register write value |
| in_wr | input | 1 | Inbound store write strobe |
| in_waddr | input | IAW | Inbound store slot |
| in_wdata | input | 8 | Inbound store byte |
| in_load | input | 1 | Start a new inbound packet |
| in_len | input | ILW | Inbound packet length, clamped to IN_DEPTH |
| ob_raddr | input | OAW | Outbound buffer read slot |
| ob_rdata | output | 8 | Outbound buffer byte at ob_raddr |
| treq_n | output | 1 | Request line to host, active low |
| shift_data | output | 8 | Shift register contents |
| sr_evt | output | 1 | One-cycle shift event pulse |
| pkt_done | output | 1 | One-cycle outbound packet complete pulse |
| pkt_len | output | OLW | Byte count of the completed packet |

## Verification
The bench builds the engine with OUT_DEPTH and IN_DEPTH both set to 4. With that depth, a few host toggles fill the outbound buffer, so the full-buffer refusal and the return to slot 0 on the following packet can both be reached. A four-slot inbound store is large enough to show the request line dropping when a packet is loaded and rising on its last byte. It is also large enough to show a second load restarting at byte 0.

// File: rtl/hs_pkg.sv
package hs_pkg;
    localparam int TIP_BIT  = 5;  // host transfer-in-progress line in the port byte
    localparam int TACK_BIT = 4;  // host acknowledge line in the port byte
    localparam int DIR_BIT  = 4;  // shift direction in the control byte, 1 = outbound
    localparam int BW       = 8;

    typedef struct packed {
        logic tip_n;
        logic tack_n;
    } hs_lines_t;
endpackage

// File: rtl/hs_line_track.sv
module hs_line_track
    import hs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          pb_wr,
    input  logic [BW-1:0] pb_wdata,
    output logic          tip_n,
    output logic          tack_n,
    output logic          last_tip_n,
    output logic          pair_chg,
    output logic          tack_chg
);
    hs_lines_t cur_d, cur_q, last_d, last_q, now_v;

    always_comb begin
        now_v = cur_q;
        if (pb_wr) begin
            now_v.tip_n  = pb_wdata[TIP_BIT];
            now_v.tack_n = pb_wdata[TACK_BIT];
        end
        cur_d  = now_v;
        last_d = upd ? now_v : last_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '{tip_n: 1'b1, tack_n: 1'b1};
            last_q <= '{tip_n: 1'b1, tack_n: 1'b1};
        end else begin
            cur_q  <= cur_d;
            last_q <= last_d;
        end
    end

    assign tip_n      = now_v.tip_n;
    assign tack_n     = now_v.tack_n;
    assign last_tip_n = last_q.tip_n;
    assign pair_chg   = (now_v != last_q);
    assign tack_chg   = (now_v.tack_n != last_q.tack_n);
endmodule

// File: rtl/hs_byte_store.sv
module hs_byte_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/hs_xfer_engine.sv
module hs_xfer_engine
    import hs_pkg::*;
#(
    parameter int OUT_DEPTH = 16,
    parameter int IN_DEPTH  = 16,
    localparam int OAW = (OUT_DEPTH > 1) ? $clog2(OUT_DEPTH) : 1,
    localparam int OLW = $clog2(OUT_DEPTH + 1),
    localparam int IAW = (IN_DEPTH > 1) ? $clog2(IN_DEPTH) : 1,
    localparam int ILW = $clog2(IN_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pb_wr,
    input  logic [7:0]     pb_wdata,
    input  logic           ctl_wr,
    input  logic [7:0]     ctl_wdata,
    input  logic           sr_wr,
    input  logic [7:0]     sr_wdata,
    input  logic           in_wr,
    input  logic [IAW-1:0] in_waddr,
    input  logic [7:0]     in_wdata,
    input  logic           in_load,
    input  logic [ILW-1:0] in_len,
    input  logic [OAW-1:0] ob_raddr,
    output logic [7:0]     ob_rdata,
    output logic           treq_n,
    output logic [7:0]     shift_data,
    output logic           sr_evt,
    output logic           pkt_done,
    output logic [OLW-1:0] pkt_len
);
    typedef struct packed {
        logic [BW-1:0]  sr;
        logic           dir_out;
        logic [OLW-1:0] oidx;
        logic [ILW-1:0] iidx;
        logic [ILW-1:0] isize;
        logic           treq_n;
        logic           evt;
        logic           done;
        logic [OLW-1:0] len;
    } eng_t;

    eng_t d, q;

    logic           upd;
    logic           tip_n, tack_n, last_tip_n, pair_chg, tack_chg;
    logic           ob_we;
    logic [BW-1:0]  sr_base;
    logic [ILW-1:0] iidx_b, isize_b;
    logic [BW-1:0]  in_rdata;

    assign upd = pb_wr | ctl_wr | in_load;

    hs_line_track u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (upd),
        .pb_wr      (pb_wr),
        .pb_wdata   (pb_wdata),
        .tip_n      (tip_n),
        .tack_n     (tack_n),
        .last_tip_n (last_tip_n),
        .pair_chg   (pair_chg),
        .tack_chg   (tack_chg)
    );

    hs_byte_store #(.DEPTH(OUT_DEPTH), .DW(BW)) u_obuf (
        .clk   (clk),
        .we    (ob_we),
        .waddr (q.oidx[OAW-1:0]),
        .wdata (sr_base),
        .raddr (ob_raddr),
        .rdata (ob_rdata)
    );

    hs_byte_store #(.DEPTH(IN_DEPTH), .DW(BW)) u_ibuf (
        .clk   (clk),
        .we    (in_wr),
        .waddr (in_waddr),
        .wdata (in_wdata),
        .raddr (iidx_b[IAW-1:0]),
        .rdata (in_rdata)
    );

    always_comb begin
        d      = q;
        d.evt  = 1'b0;
        d.done = 1'b0;
        ob_we  = 1'b0;

        sr_base = sr_wr ? sr_wdata : q.sr;
        d.sr    = sr_base;
        if (ctl_wr) d.dir_out = ctl_wdata[DIR_BIT];

        // a new inbound packet restarts the read position before evaluation
        isize_b = q.isize;
        iidx_b  = q.iidx;
        if (in_load) begin
            isize_b = (in_len > ILW'(IN_DEPTH)) ? ILW'(IN_DEPTH) : in_len;
            iidx_b  = '0;
        end
        d.isize = isize_b;
        d.iidx  = iidx_b;

        if (upd) begin
            if (!tip_n) begin
                if (d.dir_out) begin
                    if (pair_chg && (q.oidx < OLW'(OUT_DEPTH))) begin
                        ob_we  = 1'b1;
                        d.oidx = q.oidx + OLW'(1);
                        d.evt  = 1'b1;
                    end
                end else if (pair_chg && (iidx_b < isize_b)) begin
                    d.sr   = in_rdata;
                    d.iidx = iidx_b + ILW'(1);
                    if ((iidx_b + ILW'(1)) >= isize_b) d.treq_n = 1'b1;
                    d.evt  = 1'b1;
                end
            end else begin
                if (last_tip_n && tack_chg) begin
                    d.treq_n = tack_n;
                    d.evt    = 1'b1;
                end else begin
                    if (!last_tip_n) begin
                        d.evt = 1'b1;
                        if (q.oidx != '0) begin
                            d.done = 1'b1;
                            d.len  = q.oidx;
                        end
                        d.oidx = '0;
                    end
                    if (iidx_b < isize_b) d.treq_n = 1'b0;
                end
            end
            if (in_load) d.evt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.treq_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign treq_n     = q.treq_n;
    assign shift_data = q.sr;
    assign sr_evt     = q.evt;
    assign pkt_done   = q.done;
    assign pkt_len    = q.len;

    // outbound index never passes the buffer size
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.oidx <= OLW'(OUT_DEPTH));

    // every stored byte is accompanied by a shift event
    assert_store_evt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oidx > $past(q.oidx)) |-> q.evt);

    // a completion reports a nonzero length and leaves the index at slot 0
    assert_done_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.len != '0) && (q.oidx == '0) && q.evt);

    // taking the last inbound byte releases the request line
    assert_last_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.iidx == $past(q.iidx) + ILW'(1)) && (q.iidx == q.isize)) |-> q.treq_n);
endmodule

// File: tb/sim_hs_xfer_engine.sv
`timescale 1ns/10ps
module sim_hs_xfer_engine;
    localparam int OD  = 4;
    localparam int ID  = 4;
    localparam int OAW = 2;
    localparam int OLW = 3;
    localparam int IAW = 2;
    localparam int ILW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pb_wr = 0, ctl_wr = 0, sr_wr = 0, in_wr = 0, in_load = 0;
    logic [7:0]     pb_wdata = 8'h30, ctl_wdata = 0, sr_wdata = 0, in_wdata = 0;
    logic [IAW-1:0] in_waddr = 0;
    logic [ILW-1:0] in_len = 0;
    logic [OAW-1:0] ob_raddr = 0;
    logic [7:0]     ob_rdata, shift_data;
    logic           treq_n, sr_evt, pkt_done;
    logic [OLW-1:0] pkt_len;

    int checks = 0, errors = 0, pkts_seen = 0;
    bit finished = 0;
    int     exp_len_q[$];
    byte    exp_byte_q[$];
    byte    cur_pkt[$];

    always #5 clk = ~clk;

    hs_xfer_engine #(.OUT_DEPTH(OD), .IN_DEPTH(ID)) u0 (
        .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .in_wr(in_wr), .in_waddr(in_waddr), .in_wdata(in_wdata),
        .in_load(in_load), .in_len(in_len), .ob_raddr(ob_raddr), .ob_rdata(ob_rdata),
        .treq_n(treq_n), .shift_data(shift_data), .sr_evt(sr_evt),
        .pkt_done(pkt_done), .pkt_len(pkt_len)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // host port write; outputs are valid at the returning negedge
    task automatic pb(input bit tip, input bit tack);
        @(negedge clk);
        pb_wr = 1; pb_wdata = {2'b00, tip, tack, 4'h0};
        @(negedge clk);
        pb_wr = 0;
    endtask

    // host writes shift register and toggles lines in one cycle; model the store
    task automatic out_byte(input byte b, input bit tip, input bit tack, input bit expect_store);
        @(negedge clk);
        sr_wr = 1; sr_wdata = b; pb_wr = 1; pb_wdata = {2'b00, tip, tack, 4'h0};
        @(negedge clk);
        sr_wr = 0; pb_wr = 0;
        if (expect_store) cur_pkt.push_back(b);
    endtask

    task automatic ctl(input byte v);
        @(negedge clk);
        ctl_wr = 1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic push_pkt();
        exp_len_q.push_back(cur_pkt.size());
        foreach (cur_pkt[i]) exp_byte_q.push_back(cur_pkt[i]);
        cur_pkt.delete();
    endtask

    task automatic load_in(input byte b0, input byte b1, input byte b2, input int n);
        byte v[3];
        v[0] = b0; v[1] = b1; v[2] = b2;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_wr = 1; in_waddr = IAW'(i); in_wdata = v[i];
        end
        @(negedge clk);
        in_wr = 0; in_load = 1; in_len = ILW'(n);
        @(negedge clk);
        in_load = 0;
    endtask

    // monitor: compare completed packets against the scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && pkt_done) begin
            pkts_seen++;
            if (exp_len_q.size() == 0) begin
                chk("R7 unexpected pkt_done", 1, 0);
            end else begin
                int n;
                n = exp_len_q.pop_front();
                chk("R7 pkt_len", int'(pkt_len), n);
                for (int i = 0; i < n; i++) begin
                    ob_raddr = OAW'(i);
                    #0.2;
                    chk("R2 stored byte", int'(ob_rdata), int'(exp_byte_q.pop_front()) & 8'hff);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 treq_n", treq_n, 1);
        chk("R1 shift_data", shift_data, 0);
        chk("R1 sr_evt", sr_evt, 0);
        chk("R1 pkt_done", pkt_done, 0);
        rst_n = 1;
        @(negedge clk);

        // R6: idle, request follows acknowledge
        pb(1, 0);
        chk("R6 treq_n follows low", treq_n, 0);
        chk("R6 sr_evt", sr_evt, 1);
        pb(1, 1);
        chk("R6 treq_n follows high", treq_n, 1);
        chk("R6 sr_evt", sr_evt, 1);
        pb(1, 1);
        chk("R10 same lines no evt", sr_evt, 0);

        // outbound packet filling the buffer
        ctl(8'h10);
        chk("R10 ctl write no evt", sr_evt, 0);
        out_byte(8'hA1, 0, 1, 1);
        chk("R2 first store evt", sr_evt, 1);
        out_byte(8'hB2, 0, 0, 1);
        chk("R2 second store evt", sr_evt, 1);
        out_byte(8'hEE, 0, 0, 0);
        chk("R10 unchanged pair no evt", sr_evt, 0);
        out_byte(8'hC3, 0, 1, 1);
        out_byte(8'hD4, 0, 0, 1);
        chk("R2 fourth store evt", sr_evt, 1);
        out_byte(8'hFF, 0, 1, 0);
        chk("R3 full buffer no evt", sr_evt, 0);
        push_pkt();
        pb(1, 0);
        chk("R7 release evt", sr_evt, 1);
        chk("R7 release done", pkt_done, 1);
        @(negedge clk);
        chk("R7 done one cycle", pkt_done, 0);

        // next packet starts at slot 0
        pb(1, 1);
        out_byte(8'h3C, 0, 1, 1);
        push_pkt();
        pb(1, 1);
        chk("R7 second release done", pkt_done, 1);

        // empty transfer: flag but no packet
        ctl(8'h00);
        pb(0, 1);
        pb(1, 1);
        chk("R7 empty release evt", sr_evt, 1);
        chk("R7 empty release no done", pkt_done, 0);

        // inbound packet
        load_in(8'h5A, 8'hC3, 8'h00, 2);
        chk("R8 treq_n low with pending", treq_n, 0);
        chk("R9 load evt", sr_evt, 1);
        pb(0, 1);
        chk("R4 first byte", shift_data, 8'h5A);
        chk("R4 evt", sr_evt, 1);
        chk("R4 treq_n still low", treq_n, 0);
        pb(0, 0);
        chk("R4 second byte", shift_data, 8'hC3);
        chk("R5 treq_n released", treq_n, 1);
        pb(0, 0);
        chk("R10 no byte when unchanged", shift_data, 8'hC3);
        pb(1, 0);
        chk("R7 inbound release evt", sr_evt, 1);
        chk("R5 treq_n stays high", treq_n, 1);

        // reload restarts at byte 0
        load_in(8'h11, 8'h22, 8'h33, 3);
        chk("R9 reload treq_n low", treq_n, 0);
        pb(0, 1);
        chk("R9 restart at byte 0", shift_data, 8'h11);
        pb(0, 0);
        chk("R4 next byte", shift_data, 8'h22);
        chk("R4 treq_n low before last", treq_n, 0);
        pb(0, 1);
        chk("R4 last byte", shift_data, 8'h33);
        chk("R5 treq_n high at last", treq_n, 1);

        repeat (3) @(negedge clk);
        chk("R7 packets seen", pkts_seen, 2);
        chk("R7 scoreboard drained", exp_len_q.size(), 0);
        finish_run();
    end
endmodule